// File: doc/BRIEF.md
# Framed Serial Control-Word Receiver

This block is the slave end of a three-wire serial control path. A host shifts a 16-bit control word in on a data line, timed by its own serial clock. An active-low frame signal brackets the word. All three wires are asynchronous to the local system clock. They are passed through two-flop synchronizers, and the serial clock is edge-detected in the system clock domain.

Bits are taken on each falling serial-clock edge while the frame is low, with the first bit being the most significant. The host may send the word in one run of 16 clocks, or as two 8-clock bursts with the serial clock parked high between them, provided the frame stays low across the gap. When the frame returns high after exactly 16 bits, the word is committed. It is split into a 4-bit command, a 4-bit register address and an 8-bit data byte, which are presented together with a one-cycle write-valid pulse. A frame that closes early is dropped.

The output side is a valid-only stream with no ready input. The downstream register file must take every pulse in the cycle it appears, so no back-pressure is possible. The field outputs hold their value until the next commit. The system clock must run at least four times faster than the serial clock.

Top module: `sctl_word_rx`

## Requirements
- R1: While rst_n is low at a rising clock edge, wr_valid_o is 0 and wr_cmd_o, wr_addr_o and wr_data_o are all 0. The bit count and the shift register are cleared.
- R2: While frame_n_i is low, each falling edge of sclk_i shifts in one bit of sdata_i. The first bit shifted in becomes word bit 15 and the last becomes bit 0.
- R3: On commit, wr_cmd_o = word[15:12], wr_addr_o = word[11:8] and wr_data_o = word[7:0].
- R4: A rising edge of frame_n_i after exactly 16 captured bits commits the word. wr_valid_o is high for exactly one system clock cycle, and the fields are updated in that same cycle.
- R5: A word sent as two 8-bit bursts, with sclk_i idle high between the bursts and frame_n_i low throughout, is received exactly like a continuous word.
- R6: If frame_n_i rises after fewer than 16 bits, no wr_valid_o pulse is produced and the field outputs keep their previous values.
- R7: Falling sclk_i edges after the sixteenth bit in the same frame are ignored. The committed word is the first 16 bits.
- R8: wr_cmd_o, wr_addr_o and wr_data_o change only in a cycle where wr_valid_o is high.
- R9: sclk_i activity while frame_n_i is high shifts nothing. Each new frame starts counting from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sclk_i | input | 1 | Serial clock from the host; idles high |
| sdata_i | input | 1 | Serial data, sampled on the falling sclk_i edge |
| frame_n_i | input | 1 | Frame enable, active low |
| wr_valid_o | output | 1 | One-cycle write-valid pulse |
| wr_cmd_o | output | 4 | Command field of the committed word |
| wr_addr_o | output | 4 | Register address of the committed word |
| wr_data_o | output | 8 | Data byte of the committed word |

## Verification
The assertions assume that the serial inputs change slowly enough, relative to the system clock, for each sclk_i level to be seen for at least two system cycles. They also assume that sdata_i is stable around every falling sclk_i edge and that frame_n_i does not move in the same cycle as a falling sclk_i edge. The stimulus meets these assumptions as follows:
- Each sclk_i half period lasts four system cycles.
- sdata_i changes only while sclk_i is high.
- frame_n_i is moved only with sclk_i parked high, several cycles away from any clock edge.

// File: rtl/sctl_pkg.sv
package sctl_pkg;
  localparam int unsigned DEF_WORD_W  = 16;
  localparam int unsigned DEF_CMD_W   = 4;
  localparam int unsigned DEF_ADDR_W  = 4;
  localparam int unsigned DEF_STAGES  = 2;
endpackage

// File: rtl/sctl_sync.sv
module sctl_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) chain[s] <= '1;
      else if (s == 0) chain[s] <= d_i;
      else chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/sctl_edge.sv
module sctl_edge #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
  assign fall_o = ~lvl_i & prev_q;
endmodule

// File: rtl/sctl_shift.sv
module sctl_shift #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic              frame_rise,
  input  logic              bit_strobe,
  input  logic              bit_val,
  output logic [WORD_W-1:0] word_o,
  output logic              commit_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      sh_q     <= '0;
      word_o   <= '0;
      commit_o <= 1'b0;
    end else begin
      commit_o <= 1'b0;
      if (frame_n) begin
        cnt_q <= '0;
        if (frame_rise && cnt_q == FULL) begin
          word_o   <= sh_q;
          commit_o <= 1'b1;
        end
      end else if (bit_strobe && cnt_q != FULL) begin
        sh_q  <= {sh_q[WORD_W-2:0], bit_val};
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R4: the strobe never lasts two cycles
  p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |=> !commit_o) else $error("commit wider than one cycle");

  // R4: a commit follows a frame release
  p_commit_on_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |-> $past(frame_rise)) else $error("commit without frame release");

  // R7: count saturates at the word length
  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL) else $error("bit count overran");

  // R9: nothing shifts while the frame is idle
  p_idle_no_shift_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_n |=> $stable(sh_q)) else $error("shift while frame idle");
endmodule

// File: rtl/sctl_word_rx.sv
module sctl_word_rx
  import sctl_pkg::*;
#(
  parameter int unsigned WORD_W = DEF_WORD_W,
  parameter int unsigned CMD_W  = DEF_CMD_W,
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned STAGES = DEF_STAGES,
  localparam int unsigned DATA_W = WORD_W - CMD_W - ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              sdata_i,
  input  logic              frame_n_i,
  output logic              wr_valid_o,
  output logic [CMD_W-1:0]  wr_cmd_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o
);
  localparam int unsigned N_SYNC = 3;

  logic [N_SYNC-1:0] pins_s;
  logic [1:0]        rise_w, fall_w;
  logic [WORD_W-1:0] word_w;

  // pins_s: {frame_n, sclk, sdata}
  sctl_sync #(.W(N_SYNC), .STAGES(STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({frame_n_i, sclk_i, sdata_i}),
    .q_o   (pins_s)
  );

  sctl_edge #(.W(2)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (pins_s[2:1]),
    .rise_o (rise_w),
    .fall_o (fall_w)
  );

  sctl_shift #(.WORD_W(WORD_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_n    (pins_s[2]),
    .frame_rise (rise_w[1]),
    .bit_strobe (fall_w[0]),
    .bit_val    (pins_s[0]),
    .word_o     (word_w),
    .commit_o   (wr_valid_o)
  );

  assign wr_cmd_o  = word_w[WORD_W-1 -: CMD_W];
  assign wr_addr_o = word_w[DATA_W +: ADDR_W];
  assign wr_data_o = word_w[DATA_W-1:0];

  // R8: fields move only alongside the write-valid pulse
  p_fields_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid_o |-> $stable({wr_cmd_o, wr_addr_o, wr_data_o}))
    else $error("fields changed without write-valid");
endmodule

// File: tb/tb_sctl_word_rx.sv
module tb_sctl_word_rx;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b1, sdata = 1'b0, frame_n = 1'b1;
  logic wr_valid;
  logic [3:0] wr_cmd, wr_addr;
  logic [7:0] wr_data;

  int n_tests = 0, n_fail = 0, n_strobes = 0, n_expected = 0;
  logic [15:0] exp_q[$];
  logic [15:0] last_word = 16'h0000;
  logic prev_valid = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sctl_word_rx dut (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdata_i(sdata),
    .frame_n_i(frame_n), .wr_valid_o(wr_valid), .wr_cmd_o(wr_cmd),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: nbits may exceed 16 (extra bits are ones); split pauses after bit 8
  task automatic send_word(input logic [15:0] w, input int nbits, input bit split);
    frame_n = 1'b0;
    wait_cyc(6);
    for (int i = 0; i < nbits; i++) begin
      sdata = (i < 16) ? w[15-i] : 1'b1;
      wait_cyc(HALF);
      sclk = 1'b0;
      wait_cyc(HALF);
      sclk = 1'b1;
      if (split && i == 7) wait_cyc(24);
    end
    wait_cyc(HALF);
    if (nbits >= 16) begin
      exp_q.push_back(w);
      n_expected++;
      last_word = w;
    end
    frame_n = 1'b1;
    wait_cyc(12);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (wr_valid) begin
        n_strobes++;
        check(!prev_valid, "R4 pulse width", 32'(prev_valid), 32'd0);
        if (exp_q.size() == 0) begin
          check(1'b0, "R6 unexpected strobe", {16'h0, wr_cmd, wr_addr, wr_data}, 32'hFFFF_FFFF);
        end else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          check(wr_cmd == e[15:12], "R3 cmd (R2 order)", 32'(wr_cmd), 32'(e[15:12]));
          check(wr_addr == e[11:8], "R3 addr", 32'(wr_addr), 32'(e[11:8]));
          check(wr_data == e[7:0], "R3 data", 32'(wr_data), 32'(e[7:0]));
        end
      end
      prev_valid <= wr_valid;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    wait_cyc(5);
    // R1: reset state
    check(wr_valid == 1'b0, "R1 valid", 32'(wr_valid), 32'd0);
    check({wr_cmd, wr_addr, wr_data} == 16'h0, "R1 fields", 32'({wr_cmd, wr_addr, wr_data}), 32'd0);
    rst_n = 1'b1;
    wait_cyc(4);

    send_word(16'hA5C3, 16, 1'b0);   // R2 R3 R4 continuous
    send_word(16'h1234, 16, 1'b1);   // R5 two bursts
    send_word(16'hFFFF, 8, 1'b0);    // R6 abort after one byte
    check({wr_cmd, wr_addr, wr_data} == last_word, "R6 hold after abort", 32'({wr_cmd, wr_addr, wr_data}), 32'(last_word));
    send_word(16'h0000, 15, 1'b0);   // R6 abort one short
    check({wr_cmd, wr_addr, wr_data} == last_word, "R6 hold after short", 32'({wr_cmd, wr_addr, wr_data}), 32'(last_word));
    send_word(16'h5E71, 20, 1'b0);   // R7 extra bits ignored

    // R9: toggles with frame idle shift nothing
    for (int k = 0; k < 5; k++) begin
      sdata = k[0];
      wait_cyc(HALF); sclk = 1'b0;
      wait_cyc(HALF); sclk = 1'b1;
    end
    wait_cyc(6);
    check({wr_cmd, wr_addr, wr_data} == last_word, "R8 hold while idle", 32'({wr_cmd, wr_addr, wr_data}), 32'(last_word));
    send_word(16'h8001, 16, 1'b0);   // R9 fresh count
    send_word(16'h0FF0, 16, 1'b1);   // R5 again

    wait_cyc(10);
    check(n_strobes == n_expected, "R6 strobe count", 32'(n_strobes), 32'(n_expected));
    check(exp_q.size() == 0, "R4 pending words", 32'(exp_q.size()), 32'd0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule